// File: doc/BRIEF.md
# Inclusive Second-Level Snoop Filter with First-Level Residency Tracking

This block holds the tag and coherence state of an inclusive, direct-mapped second-level cache that sits between a private first-level cache and a snooping interconnect. The first-level cache never watches the bus. This block watches the bus for it and resolves every snooped read and read-exclusive from its own state. Each line carries a MESI state and two tracking bits. One bit records that the line also lives in the first-level cache. The other records that the first-level copy has been written and the second-level data is out of date.

Requests arrive one at a time on a single valid/ready port. Each request is a snooped bus read, a snooped read-exclusive, a second-level fill, a first-level fill, a first-level write hit or a first-level eviction. The block can answer with a snoop response, a flush of a line onto the bus, a back-invalidate to the first-level cache, or a data recall from it. When a snoop or an eviction needs data that only the first-level cache holds, the block stalls and raises a recall. It finishes the operation in the cycle after the first-level cache reports that the data has been written back.

Top module: `l2_snoop_filter`

## Requirements
- R1: After reset every line is invalid with both tracking bits clear, reqReady is high, and l1RecallValid, l1InvValid, busFlushValid and snpRespValid are low.
- R2: An L2 fill (reqOp 2) installs the tag of reqAddr at its index, in the state given by reqFillState (0 I, 1 S, 2 E, 3 M), with both tracking bits clear. A fill whose tag already resides at that index is ignored.
- R3: The index is the low log2(SETS) bits of reqAddr and the tag is the rest. A snooped read (reqOp 0) or read-exclusive (reqOp 1) that needs no recall pulses snpRespValid in the cycle after acceptance, with snpRespHit high exactly when the line is present.
- R4: A snooped read of a line in M flushes the request address and moves the line to S. A line in E moves to S without a flush, and a line in S is left as it is.
- R5: A snooped read-exclusive that hits invalidates the line. It flushes the line if it was in M, and it back-invalidates the request address in L1 exactly when the in-L1 bit was set.
- R6: An L1 fill (reqOp 3) sets the in-L1 bit of a resident line. For a line that is not resident it is ignored.
- R7: An L1 write hit (reqOp 4) on a resident line that has its in-L1 bit set and is in E or M moves the line to M and sets its stale bit. Otherwise it is ignored.
- R8: A snoop that would flush a stale line first raises l1RecallValid with the request address, in the cycle after acceptance. The recall stays high with reqReady low, and no response, flush or invalidate is given, until l1RecallDone is seen. In the cycle after that, the recall drops and the snoop completes as in R3 to R5.
- R9: Completing a recall clears the line's stale bit, so a later snoop of that line raises no second recall.
- R10: A fill that displaces a valid line with a different tag back-invalidates the victim address if the victim's in-L1 bit is set, and flushes the victim if it is in M. Both happen in the same cycle, one cycle after acceptance.
- R11: If the displaced victim is stale, the fill first recalls the victim address as in R8, then performs R10 in the cycle after l1RecallDone.
- R12: An L1 eviction (reqOp 5) of a resident line clears both its in-L1 bit and its stale bit. Any dirty L1 data travels with the eviction into the L2.
- R13: reqOp values 6 and 7 are ignored. They produce no output and change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqOp | input | 3 | Request kind (encoding in R2, R3, R6, R7, R12, R13) |
| reqAddr | input | ADDR_W (9) | Line address, tag above index |
| reqFillState | input | 2 | State installed by an L2 fill |
| l1RecallValid | output | 1 | Data recall request to L1, held until done |
| l1RecallAddr | output | ADDR_W (9) | Line being recalled |
| l1RecallDone | input | 1 | L1 has written the recalled data into L2 |
| l1InvValid | output | 1 | One-cycle back-invalidate to L1 |
| l1InvAddr | output | ADDR_W (9) | Line to invalidate in L1 |
| busFlushValid | output | 1 | One-cycle flush of a line onto the bus |
| busFlushAddr | output | ADDR_W (9) | Line being flushed |
| snpRespValid | output | 1 | Snoop response strobe |
| snpRespHit | output | 1 | Snooped line was present |

## Verification
The hardest case to reach from the ports is a stale victim being displaced by an L2 fill. The line has to be installed exclusive, filled into L1, and written there before a conflicting tag arrives at the same index. The bench builds that sequence on its own index, holds the recall open for several cycles so that the stall can be seen, and only then returns done. A cycle-level reference model kept in plain integer arrays follows every request. All outputs and the ready signal are compared with it on every clock, and the model's residency and stale bits are only ever read back through later snoops.

// File: rtl/l2sf_pkg.sv
package l2sf_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;

  localparam logic [2:0] OP_SNP_RD   = 3'd0;
  localparam logic [2:0] OP_SNP_RDX  = 3'd1;
  localparam logic [2:0] OP_L2_FILL  = 3'd2;
  localparam logic [2:0] OP_L1_FILL  = 3'd3;
  localparam logic [2:0] OP_L1_WRHIT = 3'd4;
  localparam logic [2:0] OP_L1_EVICT = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic  lineWr;
    mesi_e newState;
    logic  newInL1;
    logic  newStale;
    logic  flushFire;
    logic  flushVictim;
    logic  invFire;
    logic  invVictim;
    logic  recallSet;
    logic  recallVictim;
    logic  recallClr;
    logic  respFire;
    logic  respHit;
    logic  latchReq;
    logic  useLatched;
  } strobe_s;
endpackage

// File: rtl/l2sf_datapath.sv
module l2sf_datapath
  import l2sf_pkg::*;
#(
  parameter int SETS = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(SETS),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqFillState,
  input  strobe_s           strb,
  output logic [2:0]        curOp,
  output mesi_e             curState,
  output mesi_e             curFill,
  output logic              curInL1,
  output logic              curStale,
  output logic              curHit,
  output logic              l1RecallValid,
  output logic [ADDR_W-1:0] l1RecallAddr,
  output logic              l1InvValid,
  output logic [ADDR_W-1:0] l1InvAddr,
  output logic              busFlushValid,
  output logic [ADDR_W-1:0] busFlushAddr,
  output logic              snpRespValid,
  output logic              snpRespHit
);
  logic [2:0]        opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        fillQ;
  logic [ADDR_W-1:0] selAddr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  selTag;
  logic [ADDR_W-1:0] victimAddr;

  logic [TAG_W-1:0] tagMem   [SETS];
  mesi_e            stateMem [SETS];
  logic [SETS-1:0]  inL1Mem;
  logic [SETS-1:0]  staleMem;

  // request being worked on: live port when idle, held copy during a recall
  assign selAddr    = strb.useLatched ? addrQ : reqAddr;
  assign curOp      = strb.useLatched ? opQ : reqOp;
  assign curFill    = mesi_e'(strb.useLatched ? fillQ : reqFillState);
  assign idx        = selAddr[IDX_W-1:0];
  assign selTag     = selAddr[ADDR_W-1:IDX_W];
  assign curState   = stateMem[idx];
  assign curInL1    = inL1Mem[idx];
  assign curStale   = staleMem[idx];
  assign curHit     = (stateMem[idx] != ST_I) && (tagMem[idx] == selTag);
  assign victimAddr = {tagMem[idx], idx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= '0;
      addrQ <= '0;
      fillQ <= '0;
    end else if (strb.latchReq) begin
      opQ   <= reqOp;
      addrQ <= reqAddr;
      fillQ <= reqFillState;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SETS; i++) begin
        tagMem[i]   <= '0;
        stateMem[i] <= ST_I;
      end
      inL1Mem  <= '0;
      staleMem <= '0;
    end else if (strb.lineWr) begin
      tagMem[idx]   <= selTag;
      stateMem[idx] <= strb.newState;
      inL1Mem[idx]  <= strb.newInL1;
      staleMem[idx] <= strb.newStale;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      l1RecallValid <= 1'b0;
      l1RecallAddr  <= '0;
      l1InvValid    <= 1'b0;
      l1InvAddr     <= '0;
      busFlushValid <= 1'b0;
      busFlushAddr  <= '0;
      snpRespValid  <= 1'b0;
      snpRespHit    <= 1'b0;
    end else begin
      if (strb.recallSet) begin
        l1RecallValid <= 1'b1;
        l1RecallAddr  <= strb.recallVictim ? victimAddr : selAddr;
      end else if (strb.recallClr) begin
        l1RecallValid <= 1'b0;
      end
      l1InvValid    <= strb.invFire;
      if (strb.invFire) l1InvAddr <= strb.invVictim ? victimAddr : selAddr;
      busFlushValid <= strb.flushFire;
      if (strb.flushFire) busFlushAddr <= strb.flushVictim ? victimAddr : selAddr;
      snpRespValid  <= strb.respFire;
      snpRespHit    <= strb.respFire && strb.respHit;
    end
  end

  // a stale line is always an owned line that L1 still holds
  for (genvar g = 0; g < SETS; g++) begin : gStaleChk
    assert_stale_owned_R7 : assert property (@(posedge clk) disable iff (!rstN)
      staleMem[g] |-> (inL1Mem[g] && stateMem[g] == ST_M));
  end

  assert_recall_quiet_R8 : assert property (@(posedge clk) disable iff (!rstN)
    l1RecallValid |-> (!snpRespValid && !busFlushValid && !l1InvValid));

  assert_recall_hold_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (l1RecallValid && !strb.recallClr) |=> (l1RecallValid && $stable(l1RecallAddr)));
endmodule

// File: rtl/l2sf_ctrl.sv
module l2sf_ctrl
  import l2sf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       l1RecallDone,
  input  logic [2:0] curOp,
  input  mesi_e      curState,
  input  mesi_e      curFill,
  input  logic       curInL1,
  input  logic       curStale,
  input  logic       curHit,
  output logic       reqReady,
  output strobe_s    strb
);
  typedef enum logic {C_IDLE = 1'b0, C_RECALL = 1'b1} cst_e;
  cst_e    st, stNext;
  strobe_s act;
  logic    recalled, staleEff, needRecall, recVictim;

  assign reqReady = (st == C_IDLE);

  // protocol decision for the current request
  always_comb begin
    recalled     = (st == C_RECALL);
    staleEff     = curStale && !recalled;
    needRecall   = 1'b0;
    recVictim    = 1'b0;
    act          = '0;
    act.newState = curState;
    act.newInL1  = curInL1;
    act.newStale = staleEff;
    case (curOp)
      OP_SNP_RD: begin
        act.respFire = 1'b1;
        act.respHit  = curHit;
        if (curHit) begin
          act.lineWr   = 1'b1;
          act.newState = ST_S;
          if (curState == ST_M) begin
            act.flushFire = 1'b1;
            act.newStale  = 1'b0;
            needRecall    = staleEff;
          end
        end
      end
      OP_SNP_RDX: begin
        act.respFire = 1'b1;
        act.respHit  = curHit;
        if (curHit) begin
          act.lineWr   = 1'b1;
          act.newState = ST_I;
          act.newInL1  = 1'b0;
          act.newStale = 1'b0;
          act.invFire  = curInL1;
          if (curState == ST_M) begin
            act.flushFire = 1'b1;
            needRecall    = staleEff;
          end
        end
      end
      OP_L2_FILL: begin
        if (!curHit) begin
          act.lineWr   = 1'b1;
          act.newState = curFill;
          act.newInL1  = 1'b0;
          act.newStale = 1'b0;
          if (curState != ST_I) begin
            needRecall      = staleEff;
            recVictim       = 1'b1;
            act.invFire     = curInL1;
            act.invVictim   = 1'b1;
            act.flushFire   = (curState == ST_M);
            act.flushVictim = 1'b1;
          end
        end
      end
      OP_L1_FILL: begin
        if (curHit) begin
          act.lineWr  = 1'b1;
          act.newInL1 = 1'b1;
        end
      end
      OP_L1_WRHIT: begin
        if (curHit && curInL1 && (curState == ST_E || curState == ST_M)) begin
          act.lineWr   = 1'b1;
          act.newState = ST_M;
          act.newStale = 1'b1;
        end
      end
      OP_L1_EVICT: begin
        if (curHit) begin
          act.lineWr   = 1'b1;
          act.newInL1  = 1'b0;
          act.newStale = 1'b0;
        end
      end
      default: ;
    endcase
  end

  // sequencing: act now, or recall first and act on done
  always_comb begin
    strb            = '0;
    stNext          = st;
    strb.useLatched = (st == C_RECALL);
    if (st == C_IDLE && reqValid) begin
      if (needRecall) begin
        strb.latchReq     = 1'b1;
        strb.recallSet    = 1'b1;
        strb.recallVictim = recVictim;
        stNext            = C_RECALL;
      end else begin
        strb            = act;
        strb.useLatched = 1'b0;
      end
    end else if (st == C_RECALL && l1RecallDone) begin
      strb            = act;
      strb.useLatched = 1'b1;
      strb.recallClr  = 1'b1;
      stNext          = C_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= C_IDLE;
    else       st <= stNext;
  end

  assert_done_idle_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (st == C_RECALL && l1RecallDone) |=> reqReady);

  assert_recall_busy_R8 : assert property (@(posedge clk) disable iff (!rstN)
    strb.recallSet |=> (!reqReady && !strb.lineWr));
endmodule

// File: rtl/l2_snoop_filter.sv
module l2_snoop_filter
  import l2sf_pkg::*;
#(
  parameter int SETS = 8,
  parameter int TAG_W = 6,
  localparam int ADDR_W = TAG_W + $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqFillState,
  output logic              l1RecallValid,
  output logic [ADDR_W-1:0] l1RecallAddr,
  input  logic              l1RecallDone,
  output logic              l1InvValid,
  output logic [ADDR_W-1:0] l1InvAddr,
  output logic              busFlushValid,
  output logic [ADDR_W-1:0] busFlushAddr,
  output logic              snpRespValid,
  output logic              snpRespHit
);
  strobe_s    strb;
  logic [2:0] curOp;
  mesi_e      curState, curFill;
  logic       curInL1, curStale, curHit;

  l2sf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .l1RecallDone(l1RecallDone),
    .curOp(curOp), .curState(curState), .curFill(curFill), .curInL1(curInL1),
    .curStale(curStale), .curHit(curHit), .reqReady(reqReady), .strb(strb)
  );

  l2sf_datapath #(.SETS(SETS), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqFillState(reqFillState), .strb(strb), .curOp(curOp), .curState(curState),
    .curFill(curFill), .curInL1(curInL1), .curStale(curStale), .curHit(curHit),
    .l1RecallValid(l1RecallValid), .l1RecallAddr(l1RecallAddr),
    .l1InvValid(l1InvValid), .l1InvAddr(l1InvAddr),
    .busFlushValid(busFlushValid), .busFlushAddr(busFlushAddr),
    .snpRespValid(snpRespValid), .snpRespHit(snpRespHit)
  );
endmodule

// File: tb/l2_snoop_filter_bench.sv
module l2_snoop_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 8;
  localparam int AW = 9;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, l1RecallDone = 1'b0;
  logic [2:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqFillState = '0;
  logic reqReady, l1RecallValid, l1InvValid, busFlushValid, snpRespValid, snpRespHit;
  logic [AW-1:0] l1RecallAddr, l1InvAddr, busFlushAddr;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_snoop_filter u_l2_snoop_filter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqFillState(reqFillState), .l1RecallValid(l1RecallValid),
    .l1RecallAddr(l1RecallAddr), .l1RecallDone(l1RecallDone), .l1InvValid(l1InvValid),
    .l1InvAddr(l1InvAddr), .busFlushValid(busFlushValid), .busFlushAddr(busFlushAddr),
    .snpRespValid(snpRespValid), .snpRespHit(snpRespHit)
  );

  // ---------------- behavioural reference model ----------------
  int mSt[NSETS]; int mTg[NSETS]; bit mIn[NSETS]; bit mSl[NSETS];
  bit eReady, eRec, eFlush, eInv, eResp, eRespHit;
  int eRecAddr, eFlushAddr, eInvAddr;
  bit mBusy; int pOp, pAddr, pFill;

  task automatic mStep(input int op, input int addr, input int fill, input bit rec,
                       output bit needRec, output int recAddr);
    int ix = addr % NSETS;
    int tg = addr / NSETS;
    bit hit = (mSt[ix] != 0) && (mTg[ix] == tg);
    bit sl = mSl[ix] && !rec;
    needRec = 0; recAddr = 0;
    case (op)
      0: begin
        if (hit && mSt[ix] == 3 && sl) begin needRec = 1; recAddr = addr; return; end
        eResp = 1; eRespHit = hit;
        if (hit) begin
          if (mSt[ix] == 3) begin eFlush = 1; eFlushAddr = addr; end
          mSt[ix] = 1; mSl[ix] = 0;
        end
      end
      1: begin
        if (hit && mSt[ix] == 3 && sl) begin needRec = 1; recAddr = addr; return; end
        eResp = 1; eRespHit = hit;
        if (hit) begin
          if (mSt[ix] == 3) begin eFlush = 1; eFlushAddr = addr; end
          if (mIn[ix]) begin eInv = 1; eInvAddr = addr; end
          mSt[ix] = 0; mIn[ix] = 0; mSl[ix] = 0;
        end
      end
      2: begin
        if (!hit) begin
          if (mSt[ix] != 0) begin
            if (sl) begin needRec = 1; recAddr = mTg[ix] * NSETS + ix; return; end
            if (mIn[ix]) begin eInv = 1; eInvAddr = mTg[ix] * NSETS + ix; end
            if (mSt[ix] == 3) begin eFlush = 1; eFlushAddr = mTg[ix] * NSETS + ix; end
          end
          mSt[ix] = fill; mTg[ix] = tg; mIn[ix] = 0; mSl[ix] = 0;
        end
      end
      3: if (hit) mIn[ix] = 1;
      4: if (hit && mIn[ix] && mSt[ix] >= 2) begin mSt[ix] = 3; mSl[ix] = 1; end
      5: if (hit) begin mIn[ix] = 0; mSl[ix] = 0; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit nr; int ra;
    if (!rstN) begin
      for (int i = 0; i < NSETS; i++) begin mSt[i] = 0; mTg[i] = 0; mIn[i] = 0; mSl[i] = 0; end
      mBusy = 0; eRec = 0; eRecAddr = 0; eFlush = 0; eInv = 0; eResp = 0; eRespHit = 0;
      eFlushAddr = 0; eInvAddr = 0; eReady = 1;
    end else begin
      eFlush = 0; eInv = 0; eResp = 0; eRespHit = 0;
      if (mBusy) begin
        if (l1RecallDone) begin
          mStep(pOp, pAddr, pFill, 1, nr, ra);
          mBusy = 0; eRec = 0;
        end
      end else if (reqValid) begin
        mStep(int'(reqOp), int'(reqAddr), int'(reqFillState), 0, nr, ra);
        if (nr) begin
          mBusy = 1; eRec = 1; eRecAddr = ra;
          pOp = int'(reqOp); pAddr = int'(reqAddr); pFill = int'(reqFillState);
        end
      end
      eReady = !mBusy;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R8 ready", int'(reqReady), int'(eReady));
      chk("R8 recall", l1RecallValid ? 1000 + int'(l1RecallAddr) : 0, eRec ? 1000 + eRecAddr : 0);
      chk("R4 flush", busFlushValid ? 1000 + int'(busFlushAddr) : 0, eFlush ? 1000 + eFlushAddr : 0);
      chk("R5 inv", l1InvValid ? 1000 + int'(l1InvAddr) : 0, eInv ? 1000 + eInvAddr : 0);
      chk("R3 resp", snpRespValid ? 2 + int'(snpRespHit) : 0, eResp ? 2 + int'(eRespHit) : 0);
    end
  end

  // ---------------- stimulus ----------------
  function automatic int la(input int t, input int i);
    return t * NSETS + i;
  endfunction

  task automatic doReq(input int op, input int addr, input int fill);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = op[2:0]; reqAddr = addr[AW-1:0]; reqFillState = fill[1:0];
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doDone();
    l1RecallDone = 1'b1;
    @(negedge clk);
    l1RecallDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", reqReady, 1);
    chk("R1 quiet", {l1RecallValid, l1InvValid, busFlushValid, snpRespValid}, 0);
    doReq(0, la(1, 0), 0);
    chk("R1 empty miss", {snpRespValid, snpRespHit}, 2'b10);

    // R2 fill E, R4 E->S without flush
    doReq(2, la(1, 0), 2);
    doReq(0, la(1, 0), 0);
    chk("R3 hit", snpRespHit, 1);
    chk("R4 E no flush", busFlushValid, 0);

    // R4 M flush then S
    doReq(2, la(2, 1), 3);
    doReq(0, la(2, 1), 0);
    chk("R4 M flush", busFlushValid, 1);
    chk("R4 flush addr", busFlushAddr, la(2, 1));
    doReq(0, la(2, 1), 0);
    chk("R4 S no flush", busFlushValid, 0);

    // R5/R6 read-exclusive with L1 copy
    doReq(2, la(3, 2), 2);
    doReq(3, la(3, 2), 0);
    doReq(1, la(3, 2), 0);
    chk("R5 back-inv", l1InvValid, 1);
    chk("R5 inv addr", l1InvAddr, la(3, 2));
    doReq(0, la(3, 2), 0);
    chk("R5 gone", snpRespHit, 0);

    // R6 L1 fill of absent line ignored
    doReq(3, la(4, 3), 0);
    doReq(2, la(4, 3), 1);
    doReq(1, la(4, 3), 0);
    chk("R6 no inv", l1InvValid, 0);

    // R7 write hit on S ignored
    doReq(2, la(5, 4), 1);
    doReq(3, la(5, 4), 0);
    doReq(4, la(5, 4), 0);
    doReq(0, la(5, 4), 0);
    chk("R7 S ignored", {l1RecallValid, busFlushValid}, 0);

    // R8/R9 stale snoop recall
    doReq(2, la(6, 5), 2);
    doReq(3, la(6, 5), 0);
    doReq(4, la(6, 5), 0);
    doReq(0, la(6, 5), 0);
    chk("R8 recall", l1RecallValid, 1);
    chk("R8 recall addr", l1RecallAddr, la(6, 5));
    chk("R8 no resp", snpRespValid, 0);
    repeat (3) @(negedge clk);
    chk("R8 held", {l1RecallValid, reqReady}, 2'b10);
    doDone();
    chk("R8 flush after", {busFlushValid, snpRespValid, snpRespHit, l1RecallValid}, 4'b1110);
    doReq(1, la(6, 5), 0);
    chk("R9 no second recall", {l1RecallValid, busFlushValid, l1InvValid}, 3'b001);

    // R10 victim in L1 and M
    doReq(2, la(7, 6), 3);
    doReq(3, la(7, 6), 0);
    doReq(2, la(8, 6), 2);
    chk("R10 inv victim", l1InvValid ? int'(l1InvAddr) : -1, la(7, 6));
    chk("R10 flush victim", busFlushValid ? int'(busFlushAddr) : -1, la(7, 6));
    doReq(0, la(7, 6), 0);
    chk("R10 victim gone", snpRespHit, 0);
    // R2 fill of resident tag ignored (line is E, fill asks M)
    doReq(2, la(8, 6), 3);
    doReq(0, la(8, 6), 0);
    chk("R2 resident fill ignored", {snpRespHit, busFlushValid}, 2'b10);

    // R11 stale victim
    doReq(2, la(9, 7), 2);
    doReq(3, la(9, 7), 0);
    doReq(4, la(9, 7), 0);
    doReq(2, la(10, 7), 1);
    chk("R11 recall victim", l1RecallValid ? int'(l1RecallAddr) : -1, la(9, 7));
    chk("R11 no inv yet", l1InvValid, 0);
    repeat (2) @(negedge clk);
    doDone();
    chk("R11 inv+flush", {l1InvValid, busFlushValid}, 2'b11);
    doReq(1, la(10, 7), 0);
    chk("R11 new line not in L1", {snpRespHit, l1InvValid}, 2'b10);

    // R12 eviction clears tracking
    doReq(2, la(13, 2), 2);
    doReq(3, la(13, 2), 0);
    doReq(4, la(13, 2), 0);
    doReq(5, la(13, 2), 0);
    doReq(0, la(13, 2), 0);
    chk("R12 no recall", {l1RecallValid, busFlushValid}, 2'b01);
    doReq(1, la(13, 2), 0);
    chk("R12 no inv", l1InvValid, 0);

    // R13 unused opcodes
    doReq(6, la(2, 1), 3);
    chk("R13 op6 quiet", {l1RecallValid, l1InvValid, busFlushValid, snpRespValid}, 0);
    doReq(7, la(2, 1), 3);
    chk("R13 op7 quiet", {l1RecallValid, l1InvValid, busFlushValid, snpRespValid}, 0);
    doReq(0, la(2, 1), 0);
    chk("R13 line kept", {snpRespHit, busFlushValid}, 2'b10);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule